// File: doc/BRIEF.md
# Indexed Indirect Register Window

This block is the memory-mapped front end for a bank of up to 256 internal 32-bit registers, of the kind an interrupt controller uses. Software never addresses the internal registers directly. It writes an 8-bit number into an index register, then reads or writes a data window, and the access is forwarded to the internal register that the index names. A third location accepts end-of-interrupt writes and turns each one into a single-cycle strobe that carries a vector number.

All three locations sit inside one 4 KB page. The page is matched on address bits 31:12 against a page register that resets to FEC00h and can be reloaded at run time. The internal register file is outside this block. It connects through a plain interface made of an index output, a combinational read-data input, and a write strobe with write data. Only full 32-bit accesses to the decoded locations have any effect. A narrower access is dropped and flagged.

Top module: `idx_window_regs`

## Requirements
- R1: After reset the stored index is 00h, the page register holds FEC00h, and `bus_rvalid`, `size_err`, `eoi_pulse` and `reg_wr` are all low.
- R2: A full write to page offset 00h stores write data bits 7:0 as the index. A read of offset 00h returns the index in bits 7:0, and bits 31:8 always read as zero.
- R3: `reg_index` always equals the stored index. A full read of offset 10h returns the value that `reg_rdata` carries for that index in the request cycle.
- R4: A full write to offset 10h raises `reg_wr` combinationally in the request cycle, with `reg_wdata` equal to the bus write data. `reg_wr` is never high in any other case.
- R5: An access hits only when address bits 31:12 equal the page register. A miss reads as zero and changes nothing.
- R6: An access to offset 00h, 10h or 40h whose byte enables are not all ones (`bus_be` != 4'b1111) writes nothing, reads as zero, and raises `size_err` for exactly the one cycle after the request.
- R7: A full write to offset 40h raises `eoi_pulse` for the one cycle after the request, with `eoi_vector` equal to write data bits 7:0. A read of offset 40h returns zero.
- R8: Any other offset inside the page reads as zero, ignores writes and raises no flag.
- R9: When `base_load` is high, `base_value` becomes the page from the next cycle on. A request made in the same cycle as the load is decoded against the old page.
- R10: Every read request gets `bus_rvalid` high, together with its `bus_rdata`, in exactly the following cycle. `bus_rvalid` is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_load | input | 1 | Load a new page value |
| base_value | input | 20 | New page value, matched against address bits 31:12 |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read request |
| size_err | output | 1 | Partial-width access to a decoded location |
| eoi_pulse | output | 1 | End-of-interrupt strobe |
| eoi_vector | output | 8 | Vector number that goes with the strobe |
| reg_index | output | 8 | Index sent to the internal register file |
| reg_rdata | input | 32 | Contents of the indexed internal register |
| reg_wr | output | 1 | Internal register write strobe |
| reg_wdata | output | 32 | Internal register write data |

## Verification
Two things can fall in the same cycle: reloading the page base and a bus access that still targets the old page. The bench provokes this by raising `base_load` in the same cycle as a read of the index register at the old page. The read must return the index, because it was decoded against the old page. In the following cycles the same offset must answer at the new page and read as zero at the old one. The bench also puts an index write directly in front of a window access, so the window access must follow the index that was just written.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 8;
  localparam int PAGE_LSB = 12;
  localparam int PAGE_W   = ADDR_W - PAGE_LSB;
  localparam int OFF_W    = PAGE_LSB;
  localparam int BE_W     = DATA_W / 8;
  localparam int VEC_W    = 8;

  localparam logic [OFF_W-1:0] OFF_INDEX  = OFF_W'('h000);
  localparam logic [OFF_W-1:0] OFF_WINDOW = OFF_W'('h010);
  localparam logic [OFF_W-1:0] OFF_EOI    = OFF_W'('h040);

  typedef enum logic [1:0] {TGT_NONE, TGT_INDEX, TGT_WINDOW, TGT_EOI} tgt_e;

  function automatic logic page_hit(logic [ADDR_W-1:0] addr, logic [PAGE_W-1:0] page);
    return addr[ADDR_W-1:PAGE_LSB] == page;
  endfunction

  function automatic tgt_e decode_offset(logic [OFF_W-1:0] off);
    case (off)
      OFF_INDEX:  return TGT_INDEX;
      OFF_WINDOW: return TGT_WINDOW;
      OFF_EOI:    return TGT_EOI;
      default:    return TGT_NONE;
    endcase
  endfunction

  function automatic logic full_width(logic [BE_W-1:0] be);
    return &be;
  endfunction

  function automatic logic [DATA_W-1:0] read_value(tgt_e tgt, logic full,
                                                   logic [IDX_W-1:0] idx,
                                                   logic [DATA_W-1:0] win);
    if (!full) return '0;
    case (tgt)
      TGT_INDEX:  return {{(DATA_W-IDX_W){1'b0}}, idx};
      TGT_WINDOW: return win;
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/iw_decode.sv
module iw_decode
  import iw_pkg::*;
(
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [PAGE_W-1:0] page,
  output tgt_e              tgt,
  output logic              full
);
  always_comb begin
    tgt  = TGT_NONE;
    if (req && page_hit(addr, page)) tgt = decode_offset(addr[OFF_W-1:0]);
    full = full_width(be);
  end
endmodule

// File: rtl/iw_index_reg.sv
module iw_index_reg
  import iw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_val,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (wr_en) idx <= wr_val;
  end
endmodule

// File: rtl/iw_read_path.sv
module iw_read_path
  import iw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  tgt_e              tgt,
  input  logic              full,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] win_data,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) rdata <= read_value(tgt, full, idx, win_data);
    end
  end
endmodule

// File: rtl/idx_window_regs.sv
module idx_window_regs
  import iw_pkg::*;
#(
  parameter logic [19:0] RESET_PAGE = 20'hFEC00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_load,
  input  logic [19:0] base_value,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        size_err,
  output logic        eoi_pulse,
  output logic [7:0]  eoi_vector,
  output logic [7:0]  reg_index,
  input  logic [31:0] reg_rdata,
  output logic        reg_wr,
  output logic [31:0] reg_wdata
);
  logic [PAGE_W-1:0] page_q;
  tgt_e              tgt;
  logic              full;

  // named internal events, also watched by the checker
  logic ev_idx_wr, ev_win_wr, ev_eoi_wr, ev_bad_size, ev_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         page_q <= RESET_PAGE;
    else if (base_load) page_q <= base_value;
  end

  iw_decode u_dec (
    .req  (bus_req),
    .addr (bus_addr),
    .be   (bus_be),
    .page (page_q),
    .tgt  (tgt),
    .full (full)
  );

  always_comb begin
    ev_read     = bus_req && !bus_we;
    ev_idx_wr   = bus_we && full && (tgt == TGT_INDEX);
    ev_win_wr   = bus_we && full && (tgt == TGT_WINDOW);
    ev_eoi_wr   = bus_we && full && (tgt == TGT_EOI);
    ev_bad_size = !full && (tgt != TGT_NONE);
  end

  iw_index_reg u_idx (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ev_idx_wr),
    .wr_val (bus_wdata[IDX_W-1:0]),
    .idx    (reg_index)
  );

  assign reg_wr    = ev_win_wr;
  assign reg_wdata = bus_wdata;

  iw_read_path u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (ev_read),
    .tgt      (tgt),
    .full     (full),
    .idx      (reg_index),
    .win_data (reg_rdata),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_pulse  <= 1'b0;
      eoi_vector <= '0;
      size_err   <= 1'b0;
    end else begin
      eoi_pulse <= ev_eoi_wr;
      size_err  <= ev_bad_size;
      if (ev_eoi_wr) eoi_vector <= bus_wdata[VEC_W-1:0];
    end
  end
endmodule

// File: rtl/iw_checker.sv
module iw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_we,
  input logic [3:0]  bus_be,
  input logic        base_load,
  input logic        bus_rvalid,
  input logic        size_err,
  input logic        eoi_pulse,
  input logic        reg_wr,
  input logic [7:0]  reg_index,
  input logic        ev_idx_wr,
  input logic [19:0] page_q
);
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid); // R10
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid); // R10
  AST_WR_FULL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (bus_req && bus_we && bus_be == 4'hF)); // R4
  AST_ERR_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> $past(bus_req && bus_be != 4'hF)); // R6
  AST_EOI_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> $past(bus_req && bus_we && bus_be == 4'hF)); // R7
  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_idx_wr |=> $stable(reg_index)); // R2
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !base_load |=> $stable(page_q)); // R9
endmodule

bind idx_window_regs iw_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_be     (bus_be),
  .base_load  (base_load),
  .bus_rvalid (bus_rvalid),
  .size_err   (size_err),
  .eoi_pulse  (eoi_pulse),
  .reg_wr     (reg_wr),
  .reg_index  (reg_index),
  .ev_idx_wr  (ev_idx_wr),
  .page_q     (page_q)
);

// File: tb/idx_window_regs_test.sv
module idx_window_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_load = 1'b0;
  logic [19:0] base_value = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata, reg_rdata, reg_wdata;
  logic        bus_rvalid, size_err, eoi_pulse, reg_wr;
  logic [7:0]  eoi_vector, reg_index;

  logic [31:0] rf [256];
  int errors = 0, checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_window_regs uut (.*);

  // environment model of the internal register file
  assign reg_rdata = rf[reg_index];
  always @(posedge clk) if (reg_wr) rf[reg_index] <= reg_wdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data whenever a response appears
  always @(negedge clk) if (rst_n && bus_rvalid) begin
    if (exp_q.size() == 0) chk(1'b0, "R10 unexpected rvalid", bus_rdata, 32'h0);
    else begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(bus_rdata == e, t, bus_rdata, e);
    end
  end

  // driver: one access; reads push expectations, side outputs checked here
  task automatic access(input bit we, input logic [31:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, input logic [31:0] exp_rd,
                        input bit exp_err, input bit exp_wr, input bit exp_eoi,
                        input logic [7:0] exp_vec, input string tag, input bit load = 0,
                        input logic [19:0] newbase = '0);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_be = be; bus_wdata = wd;
    base_load = load; base_value = newbase;
    if (!we) begin exp_q.push_back(exp_rd); tag_q.push_back({tag, " rdata"}); end
    #1;
    chk(reg_wr == exp_wr, {tag, " reg_wr"}, 32'(reg_wr), 32'(exp_wr));
    if (exp_wr) chk(reg_wdata == wd, {tag, " reg_wdata"}, reg_wdata, wd);
    @(posedge clk); #1;
    bus_req = 1'b0; base_load = 1'b0;
    chk(size_err == exp_err, {tag, " size_err"}, 32'(size_err), 32'(exp_err));
    chk(eoi_pulse == exp_eoi, {tag, " eoi_pulse"}, 32'(eoi_pulse), 32'(exp_eoi));
    if (exp_eoi) chk(eoi_vector == exp_vec, {tag, " eoi_vector"}, 32'(eoi_vector), 32'(exp_vec));
  endtask

  localparam logic [31:0] PG   = 32'hFEC0_0000;
  localparam logic [31:0] NPG  = 32'h1234_5000;
  bit done = 0;

  initial begin
    for (int i = 0; i < 256; i++) rf[i] = 32'hA000_0000 | i;
    repeat (3) @(posedge clk);
    #1;
    chk(reg_index == 8'h00, "R1 reset index", 32'(reg_index), 0);
    chk(!bus_rvalid && !size_err && !eoi_pulse && !reg_wr, "R1 reset flags",
        {bus_rvalid, size_err, eoi_pulse, reg_wr}, 0);
    rst_n = 1'b1;
    access(0, PG, 4'hF, 0, 32'h0, 0, 0, 0, 0, "R1 index after reset");
    access(0, PG | 32'h10, 4'hF, 0, 32'hA000_0000, 0, 0, 0, 0, "R3 window idx0");
    access(1, PG, 4'hF, 32'hFFFF_FF12, 0, 0, 0, 0, 0, "R2 write index");
    access(0, PG, 4'hF, 0, 32'h12, 0, 0, 0, 0, "R2 reserved bits zero");
    access(0, PG | 32'h10, 4'hF, 0, 32'hA000_0012, 0, 0, 0, 0, "R3 window idx12");
    access(1, PG | 32'h10, 4'hF, 32'hDEAD_BEEF, 0, 0, 1, 0, 0, "R4 window write");
    access(0, PG | 32'h10, 4'hF, 0, 32'hDEAD_BEEF, 0, 0, 0, 0, "R4 window readback");
    access(1, PG, 4'hF, 32'hFF, 0, 0, 0, 0, 0, "R2 index FF");
    access(0, PG | 32'h10, 4'hF, 0, 32'hA000_00FF, 0, 0, 0, 0, "R3 window idxFF");
    // partial accesses
    access(1, PG, 4'h3, 32'h55, 0, 1, 0, 0, 0, "R6 partial index write");
    access(0, PG, 4'hF, 0, 32'hFF, 0, 0, 0, 0, "R6 index unchanged");
    access(1, PG | 32'h10, 4'hE, 32'h1111_1111, 0, 1, 0, 0, 0, "R6 partial window write");
    access(0, PG | 32'h10, 4'h1, 0, 32'h0, 1, 0, 0, 0, "R6 partial window read");
    access(0, PG | 32'h10, 4'hF, 0, 32'hA000_00FF, 0, 0, 0, 0, "R6 window unchanged");
    access(1, PG | 32'h40, 4'h7, 32'h33, 0, 1, 0, 0, 0, "R6 partial eoi write");
    // EOI
    access(1, PG | 32'h40, 4'hF, 32'hABCD_0142, 0, 0, 0, 1, 8'h42, "R7 eoi write");
    access(0, PG | 32'h40, 4'hF, 0, 32'h0, 0, 0, 0, 0, "R7 eoi read zero");
    // undecoded offsets
    access(1, PG | 32'h20, 4'hF, 32'h07, 0, 0, 0, 0, 0, "R8 undecoded write");
    access(0, PG | 32'h20, 4'hF, 0, 32'h0, 0, 0, 0, 0, "R8 undecoded read");
    access(0, PG | 32'hFFC, 4'h3, 0, 32'h0, 0, 0, 0, 0, "R8 undecoded partial");
    access(0, PG, 4'hF, 0, 32'hFF, 0, 0, 0, 0, "R8 index unchanged");
    // outside page
    access(1, NPG, 4'hF, 32'h09, 0, 0, 0, 0, 0, "R5 miss write");
    access(1, NPG | 32'h10, 4'hF, 32'h0, 0, 0, 0, 0, 0, "R5 miss window write");
    access(0, NPG, 4'hF, 0, 32'h0, 0, 0, 0, 0, "R5 miss read");
    // relocation concurrent with access
    access(0, PG, 4'hF, 0, 32'hFF, 0, 0, 0, 0, "R9 same-cycle old page", 1, 20'h12345);
    access(0, NPG, 4'hF, 0, 32'hFF, 0, 0, 0, 0, "R9 new page hit");
    access(0, PG, 4'hF, 0, 32'h0, 0, 0, 0, 0, "R9 old page miss");
    access(1, NPG, 4'hF, 32'h03, 0, 0, 0, 0, 0, "R9 index at new page");
    access(0, NPG | 32'h10, 4'hF, 0, 32'hA000_0003, 0, 0, 0, 0, "R9 window at new page");
    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "R10 missing responses", 32'(exp_q.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule